// File: doc/BRIEF.md
# Control Register Debug Port Target

This block is the target end of a narrow parallel debug port. Through it, on-chip logic reaches a bank of 16-bit PHY control registers. A single 16-bit input bus carries either a register address or a write value. Four strobes say what the bus holds and what to do with it: capture-address, capture-data, write and read. Each strobe opens a four-phase request/acknowledge exchange. The requester raises one strobe and waits for the acknowledge. It then lowers the strobe and waits for the acknowledge to fall before it starts the next step.

A register access takes several of these exchanges. The address is loaded first. For a write, a value is then captured and committed. For a read, a single read exchange returns the addressed register on the 16-bit output, and the value is valid by the time the acknowledge rises. The acknowledge timing can be set in both directions, so the block can stand in for slower register logic. The register bank here is behavioural: a parametric number of entries, selected by the low address bits.

Requests that break the handshake discipline are dropped and recorded in a sticky error flag. This covers overlapping strobes and a strobe that arrives while an exchange is still open.

Top module: `cr_port_target`

## Requirements
- R1: After reset the acknowledge is low, the read output is 0x0000, the error flag is low, and every register reads back 0x0000.
- R2: A capture-address exchange latches the input bus as the current register address.
- R3: The acknowledge rises ACK_DLY clock edges after the first edge that samples a strobe high. It falls DROP_DLY edges after the first edge that samples that strobe low. The acknowledge is never high while the block is idle.
- R4: A capture-data exchange latches the input bus as the pending write value and changes no register by itself.
- R5: A write exchange stores the pending value at the latched address. The pending value is kept, so it can be written again.
- R6: A read exchange drives the addressed register onto the read output, and the value is valid when the acknowledge rises.
- R7: If a strobe rises while more than one strobe is high, the request is not acknowledged, no latch or register changes, and the error flag is set. The flag stays set until reset.
- R8: A strobe that rises while an exchange is in progress is ignored: it gets no acknowledge and has no effect, and the error flag is set. An exchange is in progress from its start until its acknowledge has fallen.
- R9: The read output keeps its value through every other kind of exchange until the next read exchange.
- R10: Addresses 0x0000 to 0x201F are valid. A write above 0x201F is acknowledged but stores nothing. A read above 0x201F returns 0x0000.
- R11: A valid address selects the storage entry given by its low log2(DEPTH) bits. With DEPTH = 64, addresses 0x0005 and 0x0045 reach the same register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr_din | input | 16 | Shared address / write value bus |
| cap_addr | input | 1 | Capture-address strobe |
| cap_data | input | 1 | Capture-data strobe |
| wr_stb | input | 1 | Write-commit strobe |
| rd_stb | input | 1 | Read strobe |
| cr_dout | output | 16 | Read data, held until the next read |
| cr_ack | output | 1 | Handshake acknowledge |
| proto_err | output | 1 | Sticky protocol error flag |

## Verification
The assertions check four properties on every cycle. The acknowledge is low while the block is idle. The error flag never clears once set. The read output changes only just after a read strobe rises. An acknowledge that rises with no error pending follows at most one active strobe. Other behaviour only shows up in the bench's scenarios, compared against a reference register model: the exact rise and fall latency of the acknowledge, the data returned by reads, the aliasing of addresses onto storage, the handling of out-of-range addresses, and the fact that rejected requests leave the latches and registers untouched.

// File: rtl/cr_port_target.sv
module cr_port_target #(
  parameter int DW       = 16,
  parameter int DEPTH    = 64,
  parameter int ADDR_MAX = 16'h201F,
  parameter int ACK_DLY  = 2,
  parameter int DROP_DLY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cr_din,
  input  logic          cap_addr,
  input  logic          cap_data,
  input  logic          wr_stb,
  input  logic          rd_stb,
  output logic [DW-1:0] cr_dout,
  output logic          cr_ack,
  output logic          proto_err
);
  localparam int IW   = $clog2(DEPTH);
  localparam int DMAX = (ACK_DLY > DROP_DLY) ? ACK_DLY : DROP_DLY;
  localparam int CW   = $clog2(DMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_RISE, S_HOLD, S_FALL} st_t;

  st_t           st;
  logic [3:0]    s_q, act;
  logic [CW-1:0] cnt;
  logic [DW-1:0] addr, wdat;
  logic [DW-1:0] regs [DEPTH];

  wire [3:0]    s      = {rd_stb, wr_stb, cap_data, cap_addr};
  wire [3:0]    rise   = s & ~s_q;
  wire          multi  = (s & (s - 4'd1)) != 4'd0;
  wire          in_rng = 32'(addr) <= ADDR_MAX;
  wire [IW-1:0] idx    = addr[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      s_q       <= '0;
      act       <= '0;
      cnt       <= '0;
      addr      <= '0;
      wdat      <= '0;
      cr_dout   <= '0;
      cr_ack    <= 1'b0;
      proto_err <= 1'b0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      s_q <= s;
      if (|rise && (st != S_IDLE || multi)) proto_err <= 1'b1;
      case (st)
        S_IDLE: if (|rise && !multi) begin
          act <= s;
          cnt <= CW'(ACK_DLY - 1);
          st  <= S_RISE;
          if (s[0]) addr <= cr_din;
          if (s[1]) wdat <= cr_din;
          if (s[2] && in_rng) regs[idx] <= wdat;
          if (s[3]) cr_dout <= in_rng ? regs[idx] : '0;
        end
        S_RISE: if (cnt == '0) begin
          cr_ack <= 1'b1;
          st     <= S_HOLD;
        end else cnt <= cnt - 1'b1;
        S_HOLD: if ((s & act) == 4'd0) begin
          cnt <= CW'(DROP_DLY - 1);
          st  <= S_FALL;
        end
        S_FALL: if (cnt == '0) begin
          cr_ack <= 1'b0;
          st     <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cr_port_target_chk.sv
module cr_port_target_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_addr,
  input logic          cap_data,
  input logic          wr_stb,
  input logic          rd_stb,
  input logic [DW-1:0] cr_dout,
  input logic          cr_ack,
  input logic          proto_err,
  input logic          idle
);
  wire [3:0] strb = {rd_stb, wr_stb, cap_data, cap_addr};

  p_idle_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !cr_ack);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cr_ack) && !proto_err) |-> $onehot0($past(strb)));

  p_dout_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(rd_stb) && !$past(rd_stb, 2)) |-> $stable(cr_dout));
endmodule

bind cr_port_target cr_port_target_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cap_addr(cap_addr), .cap_data(cap_data),
  .wr_stb(wr_stb), .rd_stb(rd_stb), .cr_dout(cr_dout), .cr_ack(cr_ack),
  .proto_err(proto_err), .idle(st == S_IDLE)
);

// File: tb/cr_port_target_tb_top.sv
`timescale 1ns/1ps
module cr_port_target_tb_top;
  localparam int DEPTH = 64;
  localparam int AMAX  = 16'h201F;
  localparam int ACKD  = 2;
  localparam int DROPD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cr_din = '0;
  logic cap_addr = 0, cap_data = 0, wr_stb = 0, rd_stb = 0;
  logic [15:0] cr_dout;
  logic cr_ack, proto_err;

  always #10 clk = ~clk;

  cr_port_target #(.DEPTH(DEPTH), .ADDR_MAX(AMAX), .ACK_DLY(ACKD), .DROP_DLY(DROPD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cr_din(cr_din), .cap_addr(cap_addr), .cap_data(cap_data),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .cr_dout(cr_dout), .cr_ack(cr_ack), .proto_err(proto_err)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_mem [DEPTH];
  logic [15:0] m_addr, m_data, m_dout;

  function automatic logic [15:0] exp_rd(logic [15:0] a);
    return (32'(a) > AMAX) ? 16'h0000 : m_mem[a % DEPTH];
  endfunction

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic set_strb(int k, logic v);
    case (k)
      0: cap_addr = v;
      1: cap_data = v;
      2: wr_stb   = v;
      default: rd_stb = v;
    endcase
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cap_addr = 0; cap_data = 0; wr_stb = 0; rd_stb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_addr = '0; m_data = '0; m_dout = '0;
    @(negedge clk);
    chk(cr_ack == 0, "R1 ack after reset", 16'(cr_ack), 0);
    chk(cr_dout == 0, "R1 dout after reset", cr_dout, 0);
    chk(proto_err == 0, "R1 err after reset", 16'(proto_err), 0);
  endtask

  task automatic op(int k, logic [15:0] v);
    int n;
    @(negedge clk);
    cr_din = v;
    set_strb(k, 1);
    n = 0;
    while (!cr_ack && n < 40) begin @(negedge clk); n++; end
    chk(n == ACKD + 1, "R3 ack rise latency", 16'(n), 16'(ACKD + 1));
    case (k)
      0: m_addr = v;
      1: m_data = v;
      2: if (32'(m_addr) <= AMAX) m_mem[m_addr % DEPTH] = m_data;
      default: m_dout = exp_rd(m_addr);
    endcase
    if (k == 3) chk(cr_dout == m_dout, "R6 read data at ack", cr_dout, m_dout);
    else chk(cr_dout == m_dout, "R9 dout held", cr_dout, m_dout);
    set_strb(k, 0);
    n = 0;
    while (cr_ack && n < 40) begin @(negedge clk); n++; end
    chk(n == DROPD + 1, "R3 ack fall latency", 16'(n), 16'(DROPD + 1));
  endtask

  task automatic rd_at(logic [15:0] a, string req);
    op(0, a);
    op(3, 16'h0);
    chk(cr_dout == exp_rd(a), req, cr_dout, exp_rd(a));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0x0000 expected=0x0001");
    summary();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    do_reset();
    // R1: registers clear
    rd_at(16'h0000, "R1 reg clear");
    rd_at(16'h003F, "R1 reg clear");
    // R2 R5 R6
    op(0, 16'h0012); op(1, 16'hA5C3); op(2, 16'h0);
    rd_at(16'h0012, "R2 R5 write then read");
    // R4: capture data alone changes nothing
    op(1, 16'h7777);
    rd_at(16'h0012, "R4 no store on capture");
    // R5: pending value reused
    op(0, 16'h0013); op(2, 16'h0);
    rd_at(16'h0013, "R5 reuse pending");
    chk(cr_dout == 16'h7777, "R5 reuse value", cr_dout, 16'h7777);
    // R11 aliasing
    op(0, 16'h0005); op(1, 16'h1357); op(2, 16'h0);
    rd_at(16'h0045, "R11 alias 0x45 to 0x05");
    chk(cr_dout == 16'h1357, "R11 alias value", cr_dout, 16'h1357);
    // R10 boundaries
    op(0, 16'h201F); op(1, 16'h4242); op(2, 16'h0);
    rd_at(16'h201F, "R10 top valid address");
    chk(cr_dout == 16'h4242, "R10 top valid value", cr_dout, 16'h4242);
    op(0, 16'h2020); op(1, 16'hBEEF); op(2, 16'h0);
    rd_at(16'h2020, "R10 read above range");
    chk(cr_dout == 16'h0000, "R10 zero above range", cr_dout, 0);
    rd_at(16'h0020, "R10 write above range discarded");
    // R9: dout held across non-read ops
    op(0, 16'h0013); op(3, 16'h0);
    op(0, 16'h0001); op(1, 16'h9999); op(2, 16'h0);
    chk(cr_dout == 16'h7777, "R9 held through writes", cr_dout, 16'h7777);
    // random traffic
    for (int i = 0; i < 300; i++) begin
      int k, r;
      logic [15:0] v;
      k = int'($urandom % 4);
      r = int'($urandom % 10);
      if (k == 0) v = (r < 7) ? 16'($urandom % 128) : (r < 9) ? 16'($urandom % (AMAX + 1)) : 16'($urandom);
      else v = 16'($urandom);
      op(k, v);
    end
    chk(proto_err == 0, "R7 no error on clean traffic", 16'(proto_err), 0);
    // R7: two strobes at once
    op(0, 16'h0013);
    @(negedge clk);
    cr_din = 16'h0033; cap_addr = 1; cap_data = 1;
    begin
      bit seen = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (cr_ack) seen = 1; end
      chk(!seen, "R7 multi strobe not acked", 16'(seen), 0);
    end
    chk(proto_err == 1, "R7 error set", 16'(proto_err), 1);
    cap_addr = 0; cap_data = 0;
    op(3, 16'h0);
    chk(cr_dout == exp_rd(16'h0013), "R7 address unchanged", cr_dout, exp_rd(16'h0013));
    chk(proto_err == 1, "R7 error sticky", 16'(proto_err), 1);
    // R8: strobe during open exchange
    do_reset();
    op(1, 16'h1234);
    @(negedge clk);
    cr_din = 16'h0007; cap_addr = 1;
    while (!cr_ack) @(negedge clk);
    wr_stb = 1;
    repeat (3) @(negedge clk);
    chk(proto_err == 1, "R8 error on busy strobe", 16'(proto_err), 1);
    cap_addr = 0;
    while (cr_ack) @(negedge clk);
    begin
      bit seen = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (cr_ack) seen = 1; end
      chk(!seen, "R8 busy strobe not acked", 16'(seen), 0);
    end
    wr_stb = 0;
    m_addr = 16'h0007; m_data = 16'h1234;
    op(3, 16'h0);
    chk(cr_dout == 16'h0000, "R8 ignored write stored nothing", cr_dout, 0);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule